// File: doc/BRIEF.md
# Sized Add/Subtract Unit

This unit performs the integer addition and subtraction steps of a processor execute stage. It takes a source value and a destination value that have already been fetched, and returns the value to write back into the destination together with a new condition-code set. One unit covers the register form, the immediate form, the quick form (a 3-bit immediate field carried in the opcode) and the forms that target an address register. Operand fetch, effective-address calculation and the writeback itself belong to neighbouring blocks.

For a data destination the operation runs at byte, word or long width. Only the low bits of that width are replaced in the 32-bit destination. Carry, overflow, sign and zero are all taken at that width. For an address-register destination a word operand is first sign-extended, the operation always runs over the full 32 bits, and the incoming condition codes pass through unchanged. Byte width is not allowed with an address register and is reported as an illegal size.

The caller presents one request per cycle with `req_valid`. The results are registered and appear one cycle later, marked by `out_valid`.

Top module: `addsub_unit`

## Requirements
- R1: With `op_sub` = 0 the result is destination plus operand. With `op_sub` = 1 it is destination minus operand. The source input is never returned in place of the result.
- R2: `op_size` encodes 0 = byte, 1 = word, 2 = long. For a data destination at byte or word width, bits above 8 or 16 of `result` equal the destination input.
- R3: The condition-code bits are bit 4 = X, bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C. For a data destination, C is the carry out of (add) or the borrow into (subtract) the top bit of the width. V is signed overflow at that width, N is the top bit of the sized result, and Z is set when the sized result is zero.
- R4: On every add or subtract that updates the flags, X is written with the same value as C.
- R5: With `quick` = 1 the operand is the 3-bit `quick_imm` field, zero-extended: field values 1 to 7 stand for themselves and 0 stands for 8. `src_val` has no effect in this case.
- R6: With `to_areg` = 1 at word size, the operand's low 16 bits are sign-extended to 32 bits. For any legal address-register request the full 32-bit sum or difference is returned.
- R7: With `to_areg` = 1, `ccr_out` equals `ccr_in` of the same request.
- R8: Byte size with `to_areg` = 1, or size code 3, sets `illegal_size` = 1 and `write_en` = 0. It also returns the destination unchanged and `ccr_out` = `ccr_in`. Legal requests give `illegal_size` = 0 and `write_en` = 1.
- R9: Outputs are registered. `out_valid` is 1 exactly in the cycle after a cycle with `req_valid` = 1. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| src_val | input | 32 | Source operand value |
| dst_val | input | 32 | Destination operand value |
| op_sub | input | 1 | 0 = add, 1 = subtract (destination minus source) |
| op_size | input | 2 | 0 byte, 1 word, 2 long, 3 reserved |
| to_areg | input | 1 | Destination is an address register |
| quick | input | 1 | Use the quick immediate field as operand |
| quick_imm | input | 3 | Quick immediate field (0 means 8) |
| ccr_in | input | 5 | Current condition codes {X,N,Z,V,C} |
| out_valid | output | 1 | Result registers hold a new result |
| result | output | 32 | Value to write into the destination |
| ccr_out | output | 5 | New condition codes {X,N,Z,V,C} |
| write_en | output | 1 | Destination should be written |
| illegal_size | output | 1 | Size not permitted for this destination |

## Verification
Quick-immediate decoding and address-register sign extension can act on the same request. The bench provokes this by subtracting a quick field of 0 at word size from a small address value, so that the decoded 8 must pass through the 16-bit sign extension unchanged and the result must wrap across all 32 bits while the flags stay as supplied. The illegal-size check can also coincide with the quick form, through a quick byte request to an address register. That case is judged by the suppressed write, the untouched destination and the passed-through flags. Every other result is compared with an arithmetic model built from widened signed and unsigned integers rather than from bit-level carries.

// File: rtl/addsub_pkg.sv
// Shared types for the sized add/subtract unit.
// Assumes a condition-code ordering of {X,N,Z,V,C} from MSB to LSB.
package addsub_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    localparam int NUM_LANES = 3;

endpackage

// File: rtl/addsub_operand.sv
// Operand preparation: picks the quick immediate or the source value,
// then sign-extends a half-width operand for address-register targets.
// Assumes the quick field value 0 encodes 2**QUICK_W.
module addsub_operand #(
    parameter int DATA_W  = 32,
    parameter int QUICK_W = 3
) (
    input  logic [DATA_W-1:0]  src_val,
    input  logic               quick,
    input  logic [QUICK_W-1:0] quick_imm,
    input  logic               to_areg,
    input  addsub_pkg::size_e  size,
    output logic [DATA_W-1:0]  operand
);
    import addsub_pkg::*;

    localparam int HALF_W    = DATA_W / 2;
    localparam int QUICK_MAX = 1 << QUICK_W;

    logic [DATA_W-1:0] raw;

    // Select between the decoded quick immediate and the fetched source.
    always_comb begin
        if (quick) begin
            if (quick_imm == '0) raw = DATA_W'(QUICK_MAX);
            else                 raw = DATA_W'(quick_imm);
        end else begin
            raw = src_val;
        end
    end

    // Widen a half-width operand by sign when it targets an address register.
    always_comb begin
        if (to_areg && (size == SZ_WORD))
            operand = {{(DATA_W-HALF_W){raw[HALF_W-1]}}, raw[HALF_W-1:0]};
        else
            operand = raw;
    end

endmodule

// File: rtl/addsub_lane.sv
// One fixed-width adder lane with carry/borrow, overflow, sign and zero.
// Subtraction is a minus b, done as a + ~b + 1; c reports a borrow then.
module addsub_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         c,
    output logic         v,
    output logic         n,
    output logic         z
);
    logic [W:0]   ext;
    logic [W-1:0] b_eff;

    // Form the lane sum and derive its four arithmetic flags.
    always_comb begin
        b_eff = sub ? ~b : b;
        ext   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        sum   = ext[W-1:0];
        c     = ext[W] ^ sub;
        v     = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
        n     = sum[W-1];
        z     = (sum == '0);
    end

endmodule

// File: rtl/addsub_core.sv
// Runs byte, word and long lanes in parallel and selects the one that
// matches the requested size; narrower lanes keep the destination's
// upper bits. Also exposes the full-width lane for address targets.
// Assumes DATA_W is a multiple of 4.
module addsub_core #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] dst,
    input  logic [DATA_W-1:0] operand,
    input  logic              sub,
    input  addsub_pkg::size_e size,
    output logic [DATA_W-1:0] sized_res,
    output logic [DATA_W-1:0] long_res,
    output addsub_pkg::ccr_t  flags
);
    import addsub_pkg::*;

    localparam int LONG_IDX = NUM_LANES - 1;

    logic [NUM_LANES-1:0][DATA_W-1:0] lane_res;
    logic [NUM_LANES-1:0]             lane_c;
    logic [NUM_LANES-1:0]             lane_v;
    logic [NUM_LANES-1:0]             lane_n;
    logic [NUM_LANES-1:0]             lane_z;
    logic [1:0]                       sel;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam int LW = DATA_W >> (LONG_IDX - g);
        logic [LW-1:0] s;

        addsub_lane #(.W(LW)) u_lane (
            .a   (dst[LW-1:0]),
            .b   (operand[LW-1:0]),
            .sub (sub),
            .sum (s),
            .c   (lane_c[g]),
            .v   (lane_v[g]),
            .n   (lane_n[g]),
            .z   (lane_z[g])
        );

        if (LW < DATA_W) begin : g_merge
            assign lane_res[g] = {dst[DATA_W-1:LW], s};
        end else begin : g_full
            assign lane_res[g] = s;
        end
    end

    // Map the size code to a lane index.
    always_comb begin
        case (size)
            SZ_BYTE: sel = 2'd0;
            SZ_WORD: sel = 2'd1;
            default: sel = 2'(LONG_IDX);
        endcase
    end

    // Route the selected lane's result and flags; X mirrors C.
    always_comb begin
        sized_res = lane_res[sel];
        long_res  = lane_res[LONG_IDX];
        flags.x   = lane_c[sel];
        flags.n   = lane_n[sel];
        flags.z   = lane_z[sel];
        flags.v   = lane_v[sel];
        flags.c   = lane_c[sel];
    end

endmodule

// File: rtl/addsub_unit.sv
// Sized add/subtract execute unit. Combines operand preparation, the
// lane core and the size legality decision, then registers the outcome
// for one cycle. Assumes operands arrive already fetched; a write is
// suppressed for illegal sizes and the flags pass through for address
// register targets. Synchronous active-low reset.
module addsub_unit #(
    parameter int DATA_W  = 32,
    parameter int QUICK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [DATA_W-1:0] src_val,
    input  logic [DATA_W-1:0] dst_val,
    input  logic              op_sub,
    input  logic [1:0]        op_size,
    input  logic              to_areg,
    input  logic              quick,
    input  logic [QUICK_W-1:0] quick_imm,
    input  logic [4:0]        ccr_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic [4:0]        ccr_out,
    output logic              write_en,
    output logic              illegal_size
);
    import addsub_pkg::*;

    size_e             size;
    logic [DATA_W-1:0] operand;
    logic [DATA_W-1:0] sized_res;
    logic [DATA_W-1:0] long_res;
    ccr_t              core_flags;
    logic              bad_size;
    logic [DATA_W-1:0] nxt_res;
    logic [4:0]        nxt_ccr;

    assign size = size_e'(op_size);

    addsub_operand #(.DATA_W(DATA_W), .QUICK_W(QUICK_W)) u_operand (
        .src_val   (src_val),
        .quick     (quick),
        .quick_imm (quick_imm),
        .to_areg   (to_areg),
        .size      (size),
        .operand   (operand)
    );

    addsub_core #(.DATA_W(DATA_W)) u_core (
        .dst       (dst_val),
        .operand   (operand),
        .sub       (op_sub),
        .size      (size),
        .sized_res (sized_res),
        .long_res  (long_res),
        .flags     (core_flags)
    );

    // Decide legality, the value to write back and the new flags.
    always_comb begin
        bad_size = (size == SZ_RSVD) || (to_areg && (size == SZ_BYTE));
        if (bad_size) begin
            nxt_res = dst_val;
            nxt_ccr = ccr_in;
        end else if (to_areg) begin
            nxt_res = long_res;
            nxt_ccr = ccr_in;
        end else begin
            nxt_res = sized_res;
            nxt_ccr = core_flags;
        end
    end

    // Register the outcome one cycle after each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            result       <= '0;
            ccr_out      <= '0;
            write_en     <= 1'b0;
            illegal_size <= 1'b0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                result       <= nxt_res;
                ccr_out      <= nxt_ccr;
                write_en     <= !bad_size;
                illegal_size <= bad_size;
            end
        end
    end

endmodule

// File: rtl/addsub_unit_chk.sv
// Property checker for addsub_unit, attached by bind. Observes ports only.
module addsub_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        op_size,
    input logic              to_areg,
    input logic [DATA_W-1:0] dst_val,
    input logic [4:0]        ccr_in,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic [4:0]        ccr_out,
    input logic              write_en,
    input logic              illegal_size
);
    localparam int BYTE_W = DATA_W / 4;

    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid); // R9
    AST_AREG_CCR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && to_areg) |=> (ccr_out == $past(ccr_in))); // R7
    AST_X_TRACKS_C: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !to_areg && (op_size != 2'd3)) |=> (ccr_out[4] == ccr_out[0])); // R4
    AST_BYTE_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !to_areg && (op_size == 2'd0))
        |=> (result[DATA_W-1:BYTE_W] == $past(dst_val[DATA_W-1:BYTE_W]))); // R2
    AST_AREG_BYTE_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && to_areg && (op_size == 2'd0)) |=> (illegal_size && !write_en)); // R8
    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_size |-> !write_en); // R8

endmodule

bind addsub_unit addsub_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .op_size      (op_size),
    .to_areg      (to_areg),
    .dst_val      (dst_val),
    .ccr_in       (ccr_in),
    .out_valid    (out_valid),
    .result       (result),
    .ccr_out      (ccr_out),
    .write_en     (write_en),
    .illegal_size (illegal_size)
);

// File: tb/addsub_unit_test.sv
// Directed bench for addsub_unit: one task per scenario.
module addsub_unit_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] src_val = '0;
    logic [31:0] dst_val = '0;
    logic        op_sub = 1'b0;
    logic [1:0]  op_size = 2'd0;
    logic        to_areg = 1'b0;
    logic        quick = 1'b0;
    logic [2:0]  quick_imm = '0;
    logic [4:0]  ccr_in = '0;
    logic        out_valid;
    logic [31:0] result;
    logic [4:0]  ccr_out;
    logic        write_en;
    logic        illegal_size;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    addsub_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .src_val(src_val), .dst_val(dst_val), .op_sub(op_sub),
        .op_size(op_size), .to_areg(to_areg), .quick(quick),
        .quick_imm(quick_imm), .ccr_in(ccr_in), .out_valid(out_valid),
        .result(result), .ccr_out(ccr_out), .write_en(write_en),
        .illegal_size(illegal_size)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Arithmetic model from widened integers, independent of lane logic.
    task automatic model(input logic sub, input logic [1:0] sz, input logic areg,
                         input logic q, input logic [2:0] qi,
                         input logic [31:0] s, input logic [31:0] d, input logic [4:0] ci,
                         output logic [31:0] er, output logic [4:0] ec,
                         output logic ew, output logic ei);
        longint opv, mask, du, ou, r, half, ds, os, rs;
        logic [31:0] o32;
        logic c, v, n, z;
        int w;
        opv = q ? ((qi == 3'd0) ? 64'd8 : longint'(qi)) : longint'(s);
        if (sz == 2'd3 || (areg && sz == 2'd0)) begin
            er = d; ec = ci; ew = 1'b0; ei = 1'b1;
        end else if (areg) begin
            o32 = (sz == 2'd1) ? {{16{opv[15]}}, opv[15:0]} : opv[31:0];
            er = sub ? d - o32 : d + o32;
            ec = ci; ew = 1'b1; ei = 1'b0;
        end else begin
            w    = 8 << sz;
            mask = (64'd1 << w) - 1;
            half = 64'd1 << (w - 1);
            du   = longint'(d) & mask;
            ou   = opv & mask;
            r    = sub ? du - ou : du + ou;
            c    = sub ? (du < ou) : (r > mask);
            ds   = (du ^ half) - half;
            os   = (ou ^ half) - half;
            rs   = sub ? ds - os : ds + os;
            v    = (rs >= half) || (rs < -half);
            r    = r & mask;
            n    = r[w-1];
            z    = (r == 0);
            er   = (d & ~mask[31:0]) | r[31:0];
            ec   = {c, n, z, v, c};
            ew   = 1'b1; ei = 1'b0;
        end
    endtask

    // Drive one request at a falling edge and sample after the next rise.
    task automatic issue(input logic sub, input logic [1:0] sz, input logic areg,
                         input logic q, input logic [2:0] qi,
                         input logic [31:0] s, input logic [31:0] d, input logic [4:0] ci);
        @(negedge clk);
        op_sub = sub; op_size = sz; to_areg = areg; quick = q; quick_imm = qi;
        src_val = s; dst_val = d; ccr_in = ci; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic run_vs_model(input string tag, input logic sub, input logic [1:0] sz,
                                input logic areg, input logic q, input logic [2:0] qi,
                                input logic [31:0] s, input logic [31:0] d, input logic [4:0] ci);
        logic [31:0] er; logic [4:0] ec; logic ew, ei;
        model(sub, sz, areg, q, qi, s, d, ci, er, ec, ew, ei);
        issue(sub, sz, areg, q, qi, s, d, ci);
        check(tag, "out_valid", 32'(out_valid), 32'd1);
        check(tag, "result", result, er);
        check(tag, "ccr", 32'(ccr_out), 32'(ec));
        check(tag, "write_en", 32'(write_en), 32'(ew));
        check(tag, "illegal", 32'(illegal_size), 32'(ei));
    endtask

    task automatic t_reset();
        check("R9", "reset out_valid", 32'(out_valid), 32'd0);
        check("R9", "reset result", result, 32'd0);
        check("R9", "reset ccr", 32'(ccr_out), 32'd0);
        check("R9", "reset write_en", 32'(write_en), 32'd0);
    endtask

    task automatic t_add_sizes();
        // R1 R2 R3: byte 0x7F+1 overflows; upper bytes kept
        issue(1'b0, 2'd0, 1'b0, 1'b0, 3'd0, 32'h0000_0001, 32'hAABB_CC7F, 5'b0);
        check("R2", "byte add result", result, 32'hAABB_CC80);
        check("R3", "byte add ccr", 32'(ccr_out), 32'(5'b01010));
        // R3 R4: word carry out, zero result
        issue(1'b0, 2'd1, 1'b0, 1'b0, 3'd0, 32'h0000_0001, 32'h1234_FFFF, 5'b0);
        check("R2", "word add result", result, 32'h1234_0000);
        check("R4", "word carry sets X and C", 32'(ccr_out), 32'(5'b10101));
        run_vs_model("R1", 1'b0, 2'd2, 1'b0, 1'b0, 3'd0, 32'h8000_0000, 32'h8000_0000, 5'b0);
        run_vs_model("R3", 1'b0, 2'd1, 1'b0, 1'b0, 3'd0, 32'hFFFF_7000, 32'h0000_2000, 5'b0);
    endtask

    task automatic t_sub();
        // R1 R4: byte 0 - 1 borrows
        issue(1'b1, 2'd0, 1'b0, 1'b0, 3'd0, 32'h0000_0001, 32'h1234_5600, 5'b0);
        check("R1", "byte sub result", result, 32'h1234_56FF);
        check("R4", "byte borrow ccr", 32'(ccr_out), 32'(5'b11001));
        run_vs_model("R1", 1'b1, 2'd2, 1'b0, 1'b0, 3'd0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 5'b11111);
        run_vs_model("R3", 1'b1, 2'd1, 1'b0, 1'b0, 3'd0, 32'h0000_0001, 32'h5555_8000, 5'b0);
        run_vs_model("R3", 1'b1, 2'd2, 1'b0, 1'b0, 3'd0, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 5'b0);
    endtask

    task automatic t_quick();
        // R5: field 0 means 8, src_val ignored
        issue(1'b0, 2'd2, 1'b0, 1'b1, 3'd0, 32'hFFFF_FFFF, 32'h0000_0010, 5'b0);
        check("R5", "quick 8 result", result, 32'h0000_0018);
        run_vs_model("R5", 1'b1, 2'd0, 1'b0, 1'b1, 3'd3, 32'h1234_5678, 32'h0000_0002, 5'b0);
        run_vs_model("R5", 1'b0, 2'd1, 1'b0, 1'b1, 3'd7, 32'h0, 32'h0000_FFFA, 5'b0);
    endtask

    task automatic t_areg();
        // R6 R7: word 0x8000 sign-extended, flags pass through
        issue(1'b0, 2'd1, 1'b1, 1'b0, 3'd0, 32'h1111_8000, 32'h0001_0000, 5'b10101);
        check("R6", "areg word add", result, 32'h0000_8000);
        check("R7", "areg ccr hold", 32'(ccr_out), 32'(5'b10101));
        run_vs_model("R6", 1'b1, 2'd2, 1'b1, 1'b0, 3'd0, 32'h0000_0001, 32'h0000_0000, 5'b01010);
    endtask

    task automatic t_illegal();
        // R8: byte to address register, and reserved size code
        run_vs_model("R8", 1'b0, 2'd0, 1'b1, 1'b1, 3'd2, 32'h0, 32'hCAFE_0001, 5'b00110);
        run_vs_model("R8", 1'b1, 2'd3, 1'b0, 1'b0, 3'd0, 32'h5, 32'h0BAD_0BAD, 5'b11000);
        check("R8", "illegal no write", 32'(write_en), 32'd0);
    endtask

    task automatic t_coincide();
        // R5 R6: quick 8 through word sign extension, 32-bit wrap
        issue(1'b1, 2'd1, 1'b1, 1'b1, 3'd0, 32'hFFFF_FFFF, 32'h0000_0004, 5'b01100);
        check("R6", "quick areg wrap", result, 32'hFFFF_FFFC);
        check("R7", "quick areg ccr", 32'(ccr_out), 32'(5'b01100));
    endtask

    task automatic t_idle();
        // R9: a cycle without request drops out_valid
        @(negedge clk);
        check("R9", "idle out_valid", 32'(out_valid), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_add_sizes();
        t_sub();
        t_quick();
        t_areg();
        t_illegal();
        t_coincide();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule